// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by requiring it to service a 7-bit down-counter inside a bounded time slot. A free-running prescaler divides the bus clock by a fixed base ratio. A second stage then divides that result by 1, 2, 4 or 8 and produces a counting tick. Once the watchdog has been armed, each tick lowers the counter by one. A fault is raised in two cases. The first is when bit 6 of the counter clears, which is the step from 0x40 to 0x3F. The second is when software reloads the counter while its value is still above a programmed window limit. In both cases the block emits a one-cycle reset request.

When the counter steps down to 0x40, the block sets a warning flag. Software can use that flag, through an optional interrupt, to reload the counter before the deadline. Software reaches the block through a simple word-addressed write/read bus with three registers: control, configuration and status. Arming and the interrupt enable can only be set. They return to zero only on the block's reset or on its own reset request.

Top module: `winwdog`

## Requirements
- R1: After reset, control (offset 0x0) reads 0x7F, configuration (offset 0x4) reads 0x07F and status (offset 0x8) reads 0, with `irq` and `rst_req` low. In control, bits 6:0 hold the counter and bit 7 is the arm bit. In configuration, bits 6:0 hold the window, bits 8:7 hold the divide select and bit 9 holds the interrupt enable. In status, bit 0 holds the warning flag.
- R2: While the watchdog is not armed, the counter holds its value and a control write loads it. No reset request occurs, even with bit 6 of the counter clear.
- R3: The arm bit is set-only. A control write with bit 7 at 0 reloads the counter and leaves the watchdog armed.
- R4: Once armed, the counter drops by one every BASE_DIV × 2^sel bus cycles, where sel is configuration bits 8:7. The first drop comes that many cycles after the arming write.
- R5: When an armed counter steps from 0x40 to 0x3F, a reset request is issued. Arming with a loaded value below 0x40 also issues one at once.
- R6: A control write to an armed watchdog whose counter exceeds the window issues a reset request. A write when the counter equals the window does not.
- R7: The warning flag (status bit 0) is set when the armed counter steps down to 0x40. Writing 0 to it clears it, and writing 1 has no effect.
- R8: `irq` is the warning flag ANDed with the interrupt enable (configuration bit 9). The enable is set-only.
- R9: A reset request lasts exactly one cycle. It returns the counter, the arm bit, the window, the divide select, the interrupt enable and the flag to their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (4) | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
A corrupted counter or prescaler phase shows up in the control read-back after a single tick period. At the latest, it shows up as a reset request that arrives one tick early or late, or not at all. A lost or sticky arm or enable bit shows within one cycle, because a cleared arm bit stops the count and a sticky flag keeps `irq` high after a clear. A wrong window comparison shows at the first reload as either a missing reset request or an unexpected one. For that reason, the bench places reloads both exactly at the window value and above it.

// File: rtl/wdg_pkg.sv
// Package: shared constants for the windowed watchdog.
// Assumes a byte-addressed bus with word-aligned registers.
package wdg_pkg;
    localparam int CNT_W = 7;
    localparam int SEL_W = 2;
    localparam int STG_W = (1 << SEL_W) - 1;
    localparam logic [CNT_W-1:0] CNT_RST   = 7'h7F;
    localparam logic [CNT_W-1:0] WIN_RST   = 7'h7F;
    localparam logic [CNT_W-1:0] WARN_VAL  = 7'h40;
    localparam logic [CNT_W-1:0] PRE_WARN  = 7'h41;
    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_CFG  = 4'h4;
    localparam logic [3:0] OFF_STAT = 4'h8;
    localparam int ARM_BIT = 7;
    localparam int SEL_LO  = 7;
    localparam int IEN_BIT = 9;
endpackage

// File: rtl/wdg_prescaler.sv
// Module: two-stage tick generator. The first stage divides by BASE_DIV and
// the second stage keeps one of every 2^sel base wraps.
// Assumes BASE_DIV >= 2. The module is held cleared while run is low, so
// the phase starts at arming.
module wdg_prescaler #(
    parameter int BASE_DIV = 4096
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [wdg_pkg::SEL_W-1:0]  sel,
    output logic                       tick
);
    import wdg_pkg::*;
    localparam int BW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
    localparam logic [BW-1:0] BASE_MAX = BW'(BASE_DIV - 1);

    logic [BW-1:0]    base_q;
    logic [STG_W-1:0] stage_q;
    logic             base_wrap;
    logic [STG_W-1:0] mask;

    // Marks the last cycle of each base period.
    always_comb begin
        base_wrap = run && (base_q == BASE_MAX);
        mask      = STG_W'((1 << sel) - 1);
        tick      = base_wrap && ((stage_q & mask) == mask);
    end

    // Advances both divider stages and clears them when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            base_q  <= '0;
            stage_q <= '0;
        end else if (base_wrap) begin
            base_q  <= '0;
            stage_q <= stage_q + 1'b1;
        end else begin
            base_q  <= base_q + 1'b1;
        end
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdg_core.sv
// Module: watchdog down-counter with the arm bit, the window check and the
// timeout check.
// Assumes ld lasts one cycle. A load takes precedence over a tick in the
// same cycle.
module wdg_core (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       ld,
    input  logic [wdg_pkg::CNT_W-1:0]  ld_val,
    input  logic                       ld_arm,
    input  logic [wdg_pkg::CNT_W-1:0]  window,
    output logic [wdg_pkg::CNT_W-1:0]  cnt,
    output logic                       armed,
    output logic                       fault,
    output logic                       hit_warn,
    output logic                       rst_req
);
    import wdg_pkg::*;
    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             arm_q, arm_d;
    logic             early, late;

    // Computes the next counter and arm state and flags both fault kinds.
    always_comb begin
        cnt_d = cnt_q;
        arm_d = arm_q;
        if (ld) begin
            cnt_d = ld_val;
            arm_d = arm_q | ld_arm;
        end else if (arm_q && tick) begin
            cnt_d = cnt_q - 1'b1;
        end
        early    = ld && arm_q && (cnt_q > window);
        late     = arm_d && !cnt_d[MSB];
        fault    = early || late;
        hit_warn = arm_q && tick && !ld && (cnt_q == PRE_WARN);
    end

    // Holds the counter state. Any fault returns it to the reset values.
    always_ff @(posedge clk) begin
        if (!rst_n || fault) begin
            cnt_q <= CNT_RST;
            arm_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            arm_q <= arm_d;
        end
    end

    // Registers the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= fault;
    end

    assign cnt   = cnt_q;
    assign armed = arm_q;

    // R5
    armed_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> cnt_q[MSB]);
    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R9
    req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!arm_q && cnt_q == CNT_RST));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_q && !ld) |=> $stable(cnt_q));
    // R3
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !fault) |=> arm_q);
endmodule

// File: rtl/winwdog.sv
// Module: top of the windowed watchdog. It holds the configuration and
// status registers, decodes the bus and instances the prescaler and core.
// Assumes single-cycle writes and a combinational read path.
module winwdog #(
    parameter int BASE_DIV = 4096,
    parameter int AW       = 4,
    parameter int DW       = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req,
    output logic          irq
);
    import wdg_pkg::*;

    logic [CNT_W-1:0] win_q;
    logic [SEL_W-1:0] sel_q;
    logic             ien_q;
    logic             flag_q;
    logic             wr_ctrl, wr_cfg, wr_stat;
    logic             tick, fault, hit_warn, armed;
    logic [CNT_W-1:0] cnt;
    logic             unused_wdata;

    // Decodes the write strobes by offset.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == AW'(OFF_CTRL));
        wr_cfg  = bus_wr && (bus_addr == AW'(OFF_CFG));
        wr_stat = bus_wr && (bus_addr == AW'(OFF_STAT));
    end

    assign unused_wdata = ^bus_wdata[DW-1:IEN_BIT+1];

    wdg_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (armed),
        .sel  (sel_q),
        .tick (tick)
    );

    wdg_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld      (wr_ctrl),
        .ld_val  (bus_wdata[CNT_W-1:0]),
        .ld_arm  (bus_wdata[ARM_BIT]),
        .window  (win_q),
        .cnt     (cnt),
        .armed   (armed),
        .fault   (fault),
        .hit_warn(hit_warn),
        .rst_req (rst_req)
    );

    // Updates the configuration fields. The interrupt enable can only be set.
    always_ff @(posedge clk) begin
        if (!rst_n || fault) begin
            win_q <= WIN_RST;
            sel_q <= '0;
            ien_q <= 1'b0;
        end else if (wr_cfg) begin
            win_q <= bus_wdata[CNT_W-1:0];
            sel_q <= bus_wdata[SEL_LO +: SEL_W];
            ien_q <= ien_q | bus_wdata[IEN_BIT];
        end
    end

    // Sets the warning flag at 0x40. A written 0 clears it, and a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || fault)          flag_q <= 1'b0;
        else if (hit_warn)            flag_q <= 1'b1;
        else if (wr_stat && !bus_wdata[0]) flag_q <= 1'b0;
    end

    // Selects the read-back word by offset.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_CTRL))
            bus_rdata = DW'({armed, cnt});
        else if (bus_addr == AW'(OFF_CFG))
            bus_rdata = DW'({ien_q, sel_q, win_q});
        else if (bus_addr == AW'(OFF_STAT))
            bus_rdata = DW'(flag_q);
    end

    assign irq = flag_q && ien_q;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien_q);
    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (cnt == WARN_VAL));
    // R8
    ien_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q && !fault) |=> ien_q);
endmodule

// File: tb/winwdog_test.sv
module winwdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int BDIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, irq;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    winwdog #(.BASE_DIV(BDIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && rst_req) rst_seen++;

    // Monitor: pops expected and observed items and compares them.
    initial forever begin
        @(posedge clk);
        while (act_q.size() > 0) begin
            logic [31:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic push(input string t, input logic [31:0] a, input logic [31:0] e);
        tag_q.push_back(t);
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string t, input logic [3:0] a, input logic [31:0] e);
        @(negedge clk);
        bus_addr = a;
        #1;
        push(t, bus_rdata, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        // R1 reset state and register map
        do_reset();
        rd("R1 ctrl", 4'h0, 32'h7F);
        rd("R1 cfg", 4'h4, 32'h07F);
        rd("R1 stat", 4'h8, 32'h0);
        push("R1 irq", {31'b0, irq}, 32'h0);
        push("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R2 disarmed: load below 0x40, hold, no request
        do_reset();
        base = rst_seen;
        wr(4'h0, 32'h30);
        idle(200);
        rd("R2 hold", 4'h0, 32'h30);
        push("R2 no request", rst_seen - base, 0);

        // R3 / R4 divide 1, arm bit sticky
        do_reset();
        wr(4'h4, 32'h07F);
        wr(4'h0, 32'hFF);
        idle(86);
        rd("R4 div1 count", 4'h0, 32'hFA);
        wr(4'h0, 32'h7F);
        rd("R3 arm kept", 4'h0, 32'hFF);

        // R4 divide 4
        do_reset();
        wr(4'h4, 32'h17F);
        wr(4'h0, 32'hFF);
        idle(210);
        rd("R4 div4 count", 4'h0, 32'hFC);

        // R4 divide 8
        do_reset();
        wr(4'h4, 32'h1FF);
        rd("R1 cfg fields", 4'h4, 32'h1FF);
        wr(4'h0, 32'hFF);
        idle(299);
        rd("R4 div8 count", 4'h0, 32'hFD);

        // R5 / R7 / R8 / R9 warning then timeout
        do_reset();
        base = rst_seen;
        wr(4'h4, 32'h27F);
        wr(4'h0, 32'hC3);
        idle(40);
        rd("R7 flag before", 4'h8, 32'h0);
        push("R8 irq before", {31'b0, irq}, 32'h0);
        idle(8);
        push("R8 irq after warn", {31'b0, irq}, 32'h1);
        rd("R7 flag at 0x40", 4'h8, 32'h1);
        push("R5 no early timeout", rst_seen - base, 0);
        idle(20);
        push("R5 timeout request", rst_seen - base, 1);
        rd("R9 ctrl cleared", 4'h0, 32'h7F);
        rd("R9 cfg cleared", 4'h4, 32'h07F);
        rd("R9 flag cleared", 4'h8, 32'h0);
        push("R9 irq cleared", {31'b0, irq}, 32'h0);

        // R7 / R8 clear rules, enable set-only
        do_reset();
        base = rst_seen;
        wr(4'h8, 32'h1);
        rd("R7 write 1 ignored", 4'h8, 32'h0);
        wr(4'h4, 32'h27F);
        wr(4'h0, 32'hC2);
        idle(32);
        push("R8 irq set", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h0);
        rd("R7 cleared", 4'h8, 32'h0);
        push("R8 irq after clear", {31'b0, irq}, 32'h0);
        wr(4'h4, 32'h07F);
        rd("R8 enable sticky", 4'h4, 32'h27F);
        wr(4'h0, 32'hFF);
        rd("R6 refresh in window", 4'h0, 32'hFF);
        push("R6 no request", rst_seen - base, 0);

        // R6 early refresh faults, R9 single pulse
        do_reset();
        base = rst_seen;
        wr(4'h4, 32'h050);
        wr(4'h0, 32'hFF);
        idle(5);
        wr(4'h0, 32'h7F);
        idle(3);
        push("R6 early request", rst_seen - base, 1);
        rd("R9 ctrl after early", 4'h0, 32'h7F);
        rd("R9 window reset", 4'h4, 32'h07F);

        // R6 refresh exactly at window is allowed
        do_reset();
        base = rst_seen;
        wr(4'h4, 32'h07D);
        wr(4'h0, 32'hFF);
        idle(32);
        wr(4'h0, 32'hFF);
        rd("R6 equal reload", 4'h0, 32'hFF);
        push("R6 equal no request", rst_seen - base, 0);

        // R5 arming below 0x40
        do_reset();
        base = rst_seen;
        wr(4'h0, 32'hB0);
        idle(3);
        push("R5 immediate request", rst_seen - base, 1);
        rd("R5 ctrl cleared", 4'h0, 32'h7F);

        idle(3);
        wait (act_q.size() == 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule